// File: doc/BRIEF.md
# Dual-Clock Queue with Fall-Through Read Mode and Preset Thresholds

This block is a first-in/first-out queue whose write side and read side run on unrelated clocks, so a producer and a consumer may run at different rates. Each side has its own enable. The read side also has a chip select that is sampled on the read clock. Write and read pointers cross between the clock domains in Gray code, through two-flop synchronizers. The full condition is computed on the write side and the empty condition on the read side, so both are conservative: each one clears late, never early.

Two read timings can be chosen at master reset. In standard timing a word appears on the output one read-clock edge after a read request. In fall-through timing the oldest word moves to the output by itself, and each read enable retires it. The two status pins change meaning with the timing mode. The queue also reports half-full, almost-full and almost-empty. The almost thresholds come from one of eight presets latched during master reset, or from a load port that writes the almost-empty offset and then the almost-full offset. The almost flags can be registered, or taken straight from the pointer compare. A partial reset empties the queue and keeps the configuration.

Top module: `dual_clock_queue`

## Requirements
- R1: While `mrst_n` is low, the timing mode, flag mode and preset are latched from their pins on the write clock, and both pointers are held at zero. After release in standard mode: `wr_flag`=0, `rd_flag`=1, `half_full`=0, `almost_full`=0, `almost_empty`=1.
- R2: Words leave the queue in the order they were written, across independent clock rates. A pointer changes by at most one Gray bit per edge.
- R3: In standard mode `wr_flag` is 1 exactly when DEPTH words are stored. A write while full is dropped and leaves the write pointer unchanged.
- R4: In standard mode `rd_flag` is 1 exactly when no word is stored. A read while empty is dropped: the pointer and `rdata` stay as they were.
- R5: `half_full` is 1 when the stored count is at least DEPTH/2.
- R6: With count n, `almost_full` is 1 when n + AF >= DEPTH, and `almost_empty` is 1 when n <= AE (AF and AE are the active offsets).
- R7: Preset `preset_sel`=k gives AE = AF = (k+1) * max(1, DEPTH/16). This is re-latched by every master reset, which discards loaded offsets.
- R8: Each `ld_en` pulse writes `ld_val` to the next offset in the cycle AE, AF, AE, AF, ... The cycle restarts at AE after master reset.
- R9: A low pulse on `prst_n` zeroes both pointers (queue empty) and keeps the timing mode and both offsets.
- R10: With `fwft_sel`=1 at master reset, the oldest word appears on `rdata` with no read enable, and `rd_flag` is 1 while it is there. A read with chip select retires it. `wr_flag` is 1 while there is room. The total capacity is DEPTH+1 words (DEPTH in storage plus one in the output stage).
- R11: With `rd_cs` low, no read takes place. One read-clock edge later `rdata` reads zero; the held word returns one edge after `rd_cs` goes high again.
- R12: With `flag_async_sel`=0 the almost flags are registered and follow the count one edge of their own clock late. With 1 they follow the pointer compare with no output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low: clears pointers and latches configuration pins |
| prst_n | input | 1 | Partial reset, active low: clears pointers only |
| fwft_sel | input | 1 | 1 selects fall-through read timing (latched at master reset) |
| flag_async_sel | input | 1 | 1 selects unregistered almost flags (latched at master reset) |
| preset_sel | input | 3 | Threshold preset index (latched at master reset) |
| ld_en | input | 1 | Offset load strobe, write clock |
| ld_val | input | ADDR_W | Offset value to load |
| wen | input | 1 | Write enable |
| wdata | input | DATA_W | Write data |
| ren | input | 1 | Read enable |
| rd_cs | input | 1 | Synchronous read chip select |
| rdata | output | DATA_W | Read data |
| wr_flag | output | 1 | Full (standard) or room available (fall-through) |
| rd_flag | output | 1 | Empty (standard) or output word ready (fall-through) |
| almost_full | output | 1 | Almost-full flag, write domain |
| almost_empty | output | 1 | Almost-empty flag, read domain |
| half_full | output | 1 | Half-full flag, write domain |

## Verification
A pointer that skips or sticks shows up on the next read after the fault as a word out of order, repeated or missing, or as an empty/full flag that disagrees with the count of words outstanding once both synchronizers have settled, a few cycles of the slower clock later. A wrong offset or a lost configuration after partial reset shows up as an almost flag toggling one word early or late while the queue is filled one word at a time. A mixed-up flag mode shows up in the first write-clock cycle after a write that crosses the threshold. A broken fall-through stage shows up at once as a missing first word, or as the word after a read enable not matching the reference queue.

// File: rtl/dcq_pkg.sv
package dcq_pkg;

  typedef enum logic {LD_AE = 1'b0, LD_AF = 1'b1} ld_tgt_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // preset k -> (k+1) scaled to the queue depth
  function automatic int unsigned preset_offset(input logic [2:0] sel, input int unsigned aw);
    int unsigned step;
    step = (aw > 4) ? (32'd1 << (aw - 4)) : 32'd1;
    return (32'(sel) + 32'd1) * step;
  endfunction

  function automatic logic af_hit(input int unsigned cnt, input int unsigned depth,
                                  input int unsigned ofs);
    return (cnt + ofs) >= depth;
  endfunction

  function automatic logic ae_hit(input int unsigned cnt, input int unsigned ofs);
    return cnt <= ofs;
  endfunction

  function automatic logic hf_hit(input int unsigned cnt, input int unsigned depth);
    return (2 * cnt) >= depth;
  endfunction

endpackage

// File: rtl/dcq_cfg.sv
module dcq_cfg
  import dcq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              mrst_n,
  input  logic              fwft_pin,
  input  logic              async_pin,
  input  logic [2:0]        preset_sel,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_val,
  output logic              fwft,
  output logic              flag_async,
  output logic [ADDR_W-1:0] ae_ofs,
  output logic [ADDR_W-1:0] af_ofs
);

  ld_tgt_e tgt;

  // configuration is sampled on every write edge while master reset is held
  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      fwft       <= fwft_pin;
      flag_async <= async_pin;
      ae_ofs     <= ADDR_W'(preset_offset(preset_sel, ADDR_W));
      af_ofs     <= ADDR_W'(preset_offset(preset_sel, ADDR_W));
      tgt        <= LD_AE;
    end else if (ld_en) begin
      if (tgt == LD_AE) ae_ofs <= ld_val;
      else              af_ofs <= ld_val;
      tgt <= (tgt == LD_AE) ? LD_AF : LD_AE;
    end
  end

endmodule

// File: rtl/dcq_store.sv
module dcq_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/dcq_wside.sv
module dcq_wside
  import dcq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic              fwft,
  input  logic              flag_async,
  input  logic [ADDR_W-1:0] af_ofs,
  input  logic [ADDR_W:0]   rgray_async,
  output logic [ADDR_W:0]   wptr,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W:0]   wcount,
  output logic              wfire,
  output logic              wfull,
  output logic              wflag,
  output logic              almost_full,
  output logic              half_full
);

  localparam int PW = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [PW-1:0] rg_s1, rg_s2, rptr_w, wptr_nx;
  logic          af_now, af_q, hf_q;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray_async;
      rg_s2 <= rg_s1;
    end
  end

  assign rptr_w  = PW'(gray_to_bin(32'(rg_s2)));
  assign wcount  = wptr - rptr_w;
  assign wfull   = (wcount == PW'(DEPTH));
  assign wfire   = wen && !wfull;
  assign wptr_nx = wptr + 1'b1;
  assign af_now  = af_hit(32'(wcount), DEPTH, 32'(af_ofs));

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
      af_q  <= 1'b0;
      hf_q  <= 1'b0;
    end else begin
      af_q <= af_now;
      hf_q <= hf_hit(32'(wcount), DEPTH);
      if (wfire) begin
        wptr  <= wptr_nx;
        wgray <= PW'(bin_to_gray(32'(wptr_nx)));
      end
    end
  end

  assign almost_full = flag_async ? af_now : af_q;
  assign half_full   = hf_q;
  assign wflag       = fwft ? !wfull : wfull;

endmodule

// File: rtl/dcq_rside.sv
module dcq_rside
  import dcq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              ren,
  input  logic              cs,
  input  logic              fwft,
  input  logic              flag_async,
  input  logic [ADDR_W-1:0] ae_ofs,
  input  logic [ADDR_W:0]   wgray_async,
  input  logic [DATA_W-1:0] mem_q,
  output logic [ADDR_W:0]   rptr,
  output logic [ADDR_W:0]   rgray,
  output logic [ADDR_W:0]   rcount,
  output logic              rfire,
  output logic              rempty,
  output logic              rflag,
  output logic              almost_empty,
  output logic              ovalid,
  output logic [DATA_W-1:0] dout
);

  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wg_s1, wg_s2, wptr_r, rptr_nx;
  logic [DATA_W-1:0] data_q;
  logic              cs_q, ae_now, ae_q, retire;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray_async;
      wg_s2 <= wg_s1;
    end
  end

  assign wptr_r  = PW'(gray_to_bin(32'(wg_s2)));
  assign rcount  = wptr_r - rptr;
  assign rempty  = (rcount == '0);
  assign rptr_nx = rptr + 1'b1;
  assign ae_now  = ae_hit(32'(rcount), 32'(ae_ofs));
  assign retire  = fwft && cs && ren && ovalid;

  // fall-through refills the output stage whenever it is free or being retired
  assign rfire = fwft ? (cs && !rempty && (!ovalid || ren))
                      : (cs && ren && !rempty);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      rgray  <= '0;
      data_q <= '0;
      ovalid <= 1'b0;
      cs_q   <= 1'b0;
      ae_q   <= 1'b1;
    end else begin
      cs_q <= cs;
      ae_q <= ae_now;
      if (rfire) begin
        rptr   <= rptr_nx;
        rgray  <= PW'(bin_to_gray(32'(rptr_nx)));
        data_q <= mem_q;
        ovalid <= fwft;
      end else if (retire) begin
        ovalid <= 1'b0;
      end
    end
  end

  assign rflag        = fwft ? ovalid : rempty;
  assign almost_empty = flag_async ? ae_now : ae_q;
  assign dout         = cs_q ? data_q : '0;

endmodule

// File: rtl/dual_clock_queue.sv
module dual_clock_queue #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              fwft_sel,
  input  logic              flag_async_sel,
  input  logic [2:0]        preset_sel,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              wen,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ren,
  input  logic              rd_cs,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_flag,
  output logic              rd_flag,
  output logic              almost_full,
  output logic              almost_empty,
  output logic              half_full
);

  logic              ptr_rst_n;
  logic              cfg_fwft, cfg_async;
  logic [ADDR_W-1:0] cfg_ae, cfg_af;
  logic [ADDR_W:0]   w_ptr, w_gray, w_count, r_ptr, r_gray, r_count;
  logic              w_fire, w_full, r_fire, r_empty, r_ovalid;
  logic [DATA_W-1:0] mem_q;

  assign ptr_rst_n = mrst_n & prst_n;

  dcq_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .wclk(wclk), .mrst_n(mrst_n), .fwft_pin(fwft_sel), .async_pin(flag_async_sel),
    .preset_sel(preset_sel), .ld_en(ld_en), .ld_val(ld_val),
    .fwft(cfg_fwft), .flag_async(cfg_async), .ae_ofs(cfg_ae), .af_ofs(cfg_af)
  );

  dcq_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wclk(wclk), .we(w_fire), .waddr(w_ptr[ADDR_W-1:0]), .wdata(wdata),
    .raddr(r_ptr[ADDR_W-1:0]), .rdata(mem_q)
  );

  dcq_wside #(.ADDR_W(ADDR_W)) u_wside (
    .wclk(wclk), .rst_n(ptr_rst_n), .wen(wen), .fwft(cfg_fwft), .flag_async(cfg_async),
    .af_ofs(cfg_af), .rgray_async(r_gray), .wptr(w_ptr), .wgray(w_gray),
    .wcount(w_count), .wfire(w_fire), .wfull(w_full), .wflag(wr_flag),
    .almost_full(almost_full), .half_full(half_full)
  );

  dcq_rside #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rside (
    .rclk(rclk), .rst_n(ptr_rst_n), .ren(ren), .cs(rd_cs), .fwft(cfg_fwft),
    .flag_async(cfg_async), .ae_ofs(cfg_ae), .wgray_async(w_gray), .mem_q(mem_q),
    .rptr(r_ptr), .rgray(r_gray), .rcount(r_count), .rfire(r_fire), .rempty(r_empty),
    .rflag(rd_flag), .almost_empty(almost_empty), .ovalid(r_ovalid), .dout(rdata)
  );

endmodule

// File: rtl/dcq_checker.sv
module dcq_checker #(
  parameter int ADDR_W = 4
) (
  input logic            wclk,
  input logic            rclk,
  input logic            rst_n,
  input logic            wen,
  input logic            ren,
  input logic            rd_cs,
  input logic            fwft,
  input logic [ADDR_W:0] w_ptr,
  input logic [ADDR_W:0] w_gray,
  input logic [ADDR_W:0] w_count,
  input logic            w_full,
  input logic [ADDR_W:0] r_ptr,
  input logic [ADDR_W:0] r_count,
  input logic            r_empty,
  input logic            r_ovalid
);

  localparam logic [ADDR_W:0] DEPTH_P = (ADDR_W+1)'(1 << ADDR_W);

  assert_gray_step_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(w_gray ^ $past(w_gray)));

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    (w_full && wen) |=> $stable(w_ptr));

  assert_wcount_bound_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    w_count <= DEPTH_P);

  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    r_empty |=> $stable(r_ptr));

  assert_rcount_bound_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    r_count <= DEPTH_P);

  assert_fwft_hold_R10: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && r_ovalid && !(ren && rd_cs)) |=> (r_ovalid && $stable(r_ptr)));

  assert_cs_blocks_read_R11: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_cs |=> $stable(r_ptr));

endmodule

bind dual_clock_queue dcq_checker #(.ADDR_W(ADDR_W)) u_dcq_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(ptr_rst_n), .wen(wen), .ren(ren), .rd_cs(rd_cs),
  .fwft(cfg_fwft), .w_ptr(w_ptr), .w_gray(w_gray), .w_count(w_count), .w_full(w_full),
  .r_ptr(r_ptr), .r_count(r_count), .r_empty(r_empty), .r_ovalid(r_ovalid)
);

// File: tb/test_dual_clock_queue.sv
module test_dual_clock_queue;

  localparam int WPER   = 10;
  localparam int RPER   = 14;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 16;

  logic              wclk = 0, rclk = 0;
  logic              mrst_n = 0, prst_n = 1;
  logic              fwft_sel = 0, flag_async_sel = 0;
  logic [2:0]        preset_sel = 0;
  logic              ld_en = 0;
  logic [ADDR_W-1:0] ld_val = 0;
  logic              wen = 0, ren = 0, rd_cs = 1;
  logic [DATA_W-1:0] wdata = 0;
  logic [DATA_W-1:0] rdata;
  logic              wr_flag, rd_flag, almost_full, almost_empty, half_full;

  int total = 0, passed = 0;
  int ae_exp = 0, af_exp = 0;
  bit fwft_mode = 0;
  bit fire_seen = 0;
  logic [DATA_W-1:0] ref_q[$];
  logic [DATA_W-1:0] last_rd = 0;

  dual_clock_queue #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dual_clock_queue (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
    .flag_async_sel(flag_async_sel), .preset_sel(preset_sel), .ld_en(ld_en),
    .ld_val(ld_val), .wen(wen), .wdata(wdata), .ren(ren), .rd_cs(rd_cs),
    .rdata(rdata), .wr_flag(wr_flag), .rd_flag(rd_flag), .almost_full(almost_full),
    .almost_empty(almost_empty), .half_full(half_full)
  );

  always #(WPER/2) wclk = ~wclk;
  always #(RPER/2) rclk = ~rclk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  // scoreboard monitor for standard-timing reads
  always @(posedge rclk) fire_seen <= ren && rd_cs && !rd_flag && !fwft_mode;
  always @(negedge rclk) begin
    if (fire_seen) begin
      if (ref_q.size() == 0) chk(0, "R2 read with no expected word", int'(rdata), 0);
      else begin
        logic [DATA_W-1:0] e;
        e = ref_q.pop_front();
        chk(rdata == e, "R2 read order", int'(rdata), int'(e));
        last_rd = e;
      end
    end
  end

  task automatic settle();
    repeat (12) @(negedge wclk);
  endtask

  task automatic mreset(input bit fw, input bit asy, input logic [2:0] sel);
    @(negedge wclk);
    fwft_sel = fw; flag_async_sel = asy; preset_sel = sel; mrst_n = 0;
    repeat (4) @(negedge wclk);
    mrst_n = 1;
    fwft_mode = fw;
    ref_q.delete();
    ae_exp = sel + 1; af_exp = sel + 1;
    settle();
  endtask

  task automatic preset_pulse();
    @(negedge wclk); prst_n = 0;
    repeat (3) @(negedge wclk);
    prst_n = 1;
    ref_q.delete();
    settle();
  endtask

  task automatic push(input logic [DATA_W-1:0] v);
    @(negedge wclk); wen = 1; wdata = v;
    @(negedge wclk); wen = 0;
    if (ref_q.size() < (fwft_mode ? DEPTH + 1 : DEPTH)) ref_q.push_back(v);
  endtask

  task automatic pop();
    @(negedge rclk); ren = 1;
    @(negedge rclk); ren = 0;
    @(negedge rclk);
  endtask

  task automatic load(input logic [ADDR_W-1:0] v);
    @(negedge wclk); ld_en = 1; ld_val = v;
    @(negedge wclk); ld_en = 0;
  endtask

  task automatic check_flags(input int cnt, input string ctx);
    chk(wr_flag == (cnt == DEPTH), {ctx, " R3 full flag"}, int'(wr_flag), int'(cnt == DEPTH));
    chk(rd_flag == (cnt == 0), {ctx, " R4 empty flag"}, int'(rd_flag), int'(cnt == 0));
    chk(half_full == (2*cnt >= DEPTH), {ctx, " R5 half full"}, int'(half_full),
        int'(2*cnt >= DEPTH));
    chk(almost_full == (cnt + af_exp >= DEPTH), {ctx, " R6 almost full"},
        int'(almost_full), int'(cnt + af_exp >= DEPTH));
    chk(almost_empty == (cnt <= ae_exp), {ctx, " R6 almost empty"},
        int'(almost_empty), int'(cnt <= ae_exp));
  endtask

  initial begin
    #(WPER * 100000);
    chk(0, "R2 watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    // R1 / R7: master reset with preset 2 -> offsets 3
    mreset(0, 0, 3'd2);
    check_flags(0, "R1 reset state");
    for (int i = 1; i <= DEPTH; i++) begin
      push(DATA_W'(16'h1000 + i));
      settle();
      check_flags(i, "R7 preset thresholds");
    end
    // R3: write while full is dropped
    push(16'hDEAD);
    settle();
    check_flags(DEPTH, "R3 write while full");
    for (int i = 0; i < DEPTH; i++) pop();
    settle();
    check_flags(0, "R2 drained");
    chk(ref_q.size() == 0, "R3 dropped word not read", ref_q.size(), 0);

    // R4: read while empty keeps pointer and data
    pop();
    settle();
    chk(rdata == last_rd, "R4 read while empty keeps rdata", int'(rdata), int'(last_rd));
    push(16'h1234);
    settle();
    pop();
    settle();
    chk(last_rd == 16'h1234, "R4 pointer unchanged after empty read", int'(last_rd), 16'h1234);

    // R8: load AE=5, AF=2, then AE again =1
    load(4'd5); load(4'd2); load(4'd1);
    ae_exp = 1; af_exp = 2;
    settle();
    check_flags(0, "R8 loaded offsets");
    for (int i = 1; i <= DEPTH; i++) begin
      push(DATA_W'(16'h2000 + 3*i));
      settle();
      check_flags(i, "R8 loaded offsets");
    end

    // R9: partial reset empties, keeps offsets
    preset_pulse();
    check_flags(0, "R9 after partial reset");
    push(16'h0A0A); push(16'h0B0B);
    settle();
    check_flags(2, "R9 offsets kept");
    pop(); pop();
    settle();
    check_flags(0, "R9 order after partial reset");

    // R7: new master reset discards loaded offsets, preset 5 -> 6
    mreset(0, 0, 3'd5);
    for (int i = 1; i <= 11; i++) begin
      push(DATA_W'(16'h3000 + i));
      settle();
      check_flags(i, "R7 preset 5");
    end

    // R12: registered almost-full lags one write edge
    mreset(0, 0, 3'd0);
    for (int i = 0; i < 14; i++) push(DATA_W'(i));
    settle();
    push(16'h00EE);
    chk(almost_full == 1'b0, "R12 sync flag lags", int'(almost_full), 0);
    @(negedge wclk);
    chk(almost_full == 1'b1, "R12 sync flag follows", int'(almost_full), 1);

    // R12: unregistered almost-full follows at once
    mreset(0, 1, 3'd0);
    for (int i = 0; i < 14; i++) push(DATA_W'(i));
    settle();
    push(16'h00EF);
    chk(almost_full == 1'b1, "R12 async flag immediate", int'(almost_full), 1);

    // R11: chip select
    mreset(0, 0, 3'd0);
    push(16'hAAA1); push(16'hBBB2); push(16'hCCC3);
    settle();
    pop();
    @(negedge rclk); rd_cs = 0;
    @(negedge rclk);
    chk(rdata == '0, "R11 idle output", int'(rdata), 0);
    ren = 1;
    @(negedge rclk); ren = 0;
    @(negedge rclk);
    chk(rdata == '0, "R11 idle during read request", int'(rdata), 0);
    rd_cs = 1;
    @(negedge rclk);
    chk(rdata == 16'hAAA1, "R11 no read while deselected", int'(rdata), 16'hAAA1);
    pop(); pop();
    settle();
    chk(rd_flag == 1'b1, "R11 queue drained", int'(rd_flag), 1);

    // R10: fall-through timing
    mreset(1, 0, 3'd0);
    chk(rd_flag == 1'b0, "R10 not ready when empty", int'(rd_flag), 0);
    chk(wr_flag == 1'b1, "R10 room available", int'(wr_flag), 1);
    push(16'h5A5A);
    settle();
    chk(rd_flag == 1'b1, "R10 ready without read enable", int'(rd_flag), 1);
    chk(rdata == 16'h5A5A, "R10 first word falls through", int'(rdata), 16'h5A5A);
    for (int i = 1; i <= DEPTH - 1; i++) push(DATA_W'(16'h6000 + i));
    settle();
    chk(wr_flag == 1'b1, "R10 room with one slot left", int'(wr_flag), 1);
    push(16'h6FFF);
    settle();
    chk(wr_flag == 1'b0, "R10 no room at DEPTH+1", int'(wr_flag), 0);
    while (ref_q.size() > 0) begin
      logic [DATA_W-1:0] e;
      e = ref_q.pop_front();
      chk(rdata == e, "R10 fall-through order", int'(rdata), int'(e));
      @(negedge rclk); ren = 1;
      @(negedge rclk); ren = 0;
    end
    settle();
    chk(rd_flag == 1'b0, "R10 drained", int'(rd_flag), 0);

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

endmodule